// File: doc/BRIEF.md
# Configurable Logic Macrocell

This block is one output cell of a sum-of-products logic array. It takes eight product terms from a shared AND plane. An allocation mask chooses which of those terms feed a wide OR gate. A polarity bit can then invert the OR result; this inverted-or-not value is called the sum below. The sum drives a single storage bit. A three-bit mode field sets how that bit behaves: D, toggle, JK, set/reset, or a transparent pass-through. A bypass bit picks what the cell presents on its output: the sum taken straight through, or the stored path.

A separate feedback output always carries the register's state back to the routing fabric. The fabric can therefore read the stored bit even when the output pin is bypassed. The JK and set/reset modes need a second input. A dedicated product term, `kr_term`, supplies it.

The storage bit is written as a two-state machine with two states. `Q_CLR` means the bit holds 0 and `Q_SET` means it holds 1. An asynchronous reset forces `Q_CLR`. On each rising clock edge the next state is chosen from the mode, as follows:
- **D:** the next state is `Q_SET` when the sum is 1, otherwise `Q_CLR`.
- **Toggle:** the state flips between `Q_CLR` and `Q_SET` when the sum is 1, and stays put when it is 0.
- **JK:** `kr_term` is 0 and the sum is 1 goes to `Q_SET`. `kr_term` is 1 and the sum is 0 goes to `Q_CLR`. Both 1 flips the state. Both 0 keeps it.
- **Set/reset:** the same as JK, except that both inputs high keeps the state.
- **Transparent:** the state follows the sum, as in D mode.
- **Unused mode codes:** the state is kept.

Top module: `mc_cell`

## Requirements
- R1: The OR stage outputs the OR of `pterm[i] & alloc_mask[i]` over all eight bits, so a term whose mask bit is 0 has no effect and an all-zero mask gives 0.
- R2: When `invert` is 1 the sum is the complement of the OR result; when 0 it equals it.
- R3: With `ff_mode` = 3'b000 (D), each rising clock edge loads the sum into the register.
- R4: With `ff_mode` = 3'b001 (toggle), the register inverts on a rising edge when the sum is 1 and holds when it is 0.
- R5: With `ff_mode` = 3'b010 (JK), J is the sum and K is `kr_term`: 00 holds, 10 sets, 01 clears, 11 toggles.
- R6: With `ff_mode` = 3'b011 (set/reset), S is the sum and R is `kr_term`: 10 sets, 01 clears, 00 and 11 both hold.
- R7: With `ff_mode` = 3'b100 (transparent), the stored path equals the sum in the same cycle without waiting for a clock edge, and the register also captures the sum on each edge.
- R8: When `bypass` is 1, `mc_out` equals the sum whatever the mode. When `bypass` is 0, `mc_out` is the stored path.
- R9: `fb_out` always equals the register state, independent of `bypass` and of the current sum.
- R10: An active-low `rst_n` clears the register at once, without a clock edge.
- R11: Mode codes 3'b101 to 3'b111 hold the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low register clear |
| pterm | input | 8 | Product terms from the AND plane |
| alloc_mask | input | 8 | Per-term enable into the OR gate |
| invert | input | 1 | Polarity bit applied after the OR |
| kr_term | input | 1 | Dedicated product term used as K or R |
| ff_mode | input | 3 | Storage behaviour select |
| bypass | input | 1 | 1 routes the sum straight to the output |
| mc_out | output | 1 | Cell output |
| fb_out | output | 1 | Register state fed back to the fabric |

## Verification
On every clock cycle, the checker watches several behaviours. It confirms that D mode loads the sum. It confirms that toggle mode flips the register when the sum is 1. It confirms that set/reset mode holds when both S and R are high. It also checks two combinational relations against its own copy of the masked OR: the bypass path, and the zero output produced by an empty mask.

Some behaviours only the bench scenarios can show. These are the full JK truth table and the hold on unused mode codes. They also include the transparent path following a mid-cycle change in `pterm`, and the register clearing while reset is asserted between clock edges.

// File: rtl/mc_pkg.sv
package mc_pkg;
    localparam int PT_W   = 8;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        FF_D     = 3'b000,
        FF_T     = 3'b001,
        FF_JK    = 3'b010,
        FF_SR    = 3'b011,
        FF_TRANS = 3'b100
    } ff_mode_e;

    typedef enum logic {
        Q_CLR = 1'b0,
        Q_SET = 1'b1
    } q_state_e;
endpackage

// File: rtl/mc_sum.sv
module mc_sum #(
    parameter int PT_W = 8
) (
    input  logic [PT_W-1:0] pterm,
    input  logic [PT_W-1:0] alloc_mask,
    input  logic            invert,
    output logic            sum
);
    logic [PT_W-1:0] gated;
    logic            or_out;

    genvar g;
    generate
        for (g = 0; g < PT_W; g++) begin : g_gate
            assign gated[g] = pterm[g] & alloc_mask[g];
        end
    endgenerate

    assign or_out = |gated;
    assign sum    = or_out ^ invert;
endmodule

// File: rtl/mc_ff.sv
module mc_ff
    import mc_pkg::*;
#(
    parameter int MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sum,
    input  logic              kr_term,
    input  logic [MODE_W-1:0] ff_mode,
    output logic              q,
    output logic              stored
);
    q_state_e state, state_nxt;
    q_state_e flipped;

    assign flipped = (state == Q_SET) ? Q_CLR : Q_SET;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= Q_CLR;
        else        state <= state_nxt;
    end

    // next-state selection by mode
    always_comb begin
        state_nxt = state;
        unique case (ff_mode)
            FF_D, FF_TRANS: state_nxt = sum ? Q_SET : Q_CLR;
            FF_T:           state_nxt = sum ? flipped : state;
            FF_JK: begin
                unique case ({sum, kr_term})
                    2'b10:   state_nxt = Q_SET;
                    2'b01:   state_nxt = Q_CLR;
                    2'b11:   state_nxt = flipped;
                    default: state_nxt = state;
                endcase
            end
            FF_SR: begin
                unique case ({sum, kr_term})
                    2'b10:   state_nxt = Q_SET;
                    2'b01:   state_nxt = Q_CLR;
                    default: state_nxt = state;
                endcase
            end
            default:        state_nxt = state;
        endcase
    end

    // outputs
    always_comb begin
        q      = (state == Q_SET);
        stored = (ff_mode == FF_TRANS) ? sum : q;
    end
endmodule

// File: rtl/mc_outsel.sv
module mc_outsel (
    input  logic bypass,
    input  logic sum,
    input  logic stored,
    output logic mc_out
);
    assign mc_out = bypass ? sum : stored;
endmodule

// File: rtl/mc_cell.sv
module mc_cell
    import mc_pkg::*;
#(
    parameter int PT_W   = mc_pkg::PT_W,
    parameter int MODE_W = mc_pkg::MODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PT_W-1:0]   pterm,
    input  logic [PT_W-1:0]   alloc_mask,
    input  logic              invert,
    input  logic              kr_term,
    input  logic [MODE_W-1:0] ff_mode,
    input  logic              bypass,
    output logic              mc_out,
    output logic              fb_out
);
    logic sum;
    logic q;
    logic stored;

    mc_sum #(.PT_W(PT_W)) u_sum (
        .pterm      (pterm),
        .alloc_mask (alloc_mask),
        .invert     (invert),
        .sum        (sum)
    );

    mc_ff #(.MODE_W(MODE_W)) u_ff (
        .clk     (clk),
        .rst_n   (rst_n),
        .sum     (sum),
        .kr_term (kr_term),
        .ff_mode (ff_mode),
        .q       (q),
        .stored  (stored)
    );

    mc_outsel u_sel (
        .bypass (bypass),
        .sum    (sum),
        .stored (stored),
        .mc_out (mc_out)
    );

    assign fb_out = q;
endmodule

// File: rtl/mc_cell_chk.sv
module mc_cell_chk #(
    parameter int PT_W   = 8,
    parameter int MODE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PT_W-1:0]   pterm,
    input logic [PT_W-1:0]   alloc_mask,
    input logic              invert,
    input logic              kr_term,
    input logic [MODE_W-1:0] ff_mode,
    input logic              bypass,
    input logic              mc_out,
    input logic              fb_out
);
    logic ref_sum;
    assign ref_sum = (|(pterm & alloc_mask)) ^ invert;

    // R3
    d_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ff_mode == 3'b000) |=> (fb_out == $past(ref_sum)));

    // R4
    t_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ff_mode == 3'b001 && ref_sum) |=> (fb_out != $past(fb_out)));

    // R6
    sr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ff_mode == 3'b011 && ref_sum && kr_term) |=> $stable(fb_out));

    // R8
    bypass_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |-> (mc_out == ref_sum));

    // R1
    empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_mask == '0 && !invert && bypass) |-> !mc_out);
endmodule

bind mc_cell mc_cell_chk #(.PT_W(PT_W), .MODE_W(MODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pterm      (pterm),
    .alloc_mask (alloc_mask),
    .invert     (invert),
    .kr_term    (kr_term),
    .ff_mode    (ff_mode),
    .bypass     (bypass),
    .mc_out     (mc_out),
    .fb_out     (fb_out)
);

// File: tb/mc_cell_test.sv
module mc_cell_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pterm = '0;
    logic [7:0] alloc_mask = '0;
    logic       invert = 1'b0;
    logic       kr_term = 1'b0;
    logic [2:0] ff_mode = '0;
    logic       bypass = 1'b0;
    logic       mc_out;
    logic       fb_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mc_cell uut (
        .clk(clk), .rst_n(rst_n), .pterm(pterm), .alloc_mask(alloc_mask),
        .invert(invert), .kr_term(kr_term), .ff_mode(ff_mode), .bypass(bypass),
        .mc_out(mc_out), .fb_out(fb_out)
    );

    typedef struct packed {
        logic [7:0] pt;
        logic [7:0] mk;
        logic       inv;
        logic       kr;
        logic [2:0] md;
        logic       byp;
        logic       eo;
        logic       ef;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{8'h01, 8'h01, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1}, // R3 R1 load 1
        '{8'h01, 8'hFE, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0}, // R1 masked term
        '{8'h00, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1}, // R2 invert
        '{8'h80, 8'h80, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0}, // R4 toggle
        '{8'h80, 8'h80, 1'b0, 1'b0, 3'd1, 1'b0, 1'b1, 1'b1}, // R4 toggle
        '{8'h00, 8'h80, 1'b0, 1'b0, 3'd1, 1'b0, 1'b1, 1'b1}, // R4 hold
        '{8'h02, 8'h02, 1'b0, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0}, // R5 J=K=1
        '{8'h02, 8'h02, 1'b0, 1'b0, 3'd2, 1'b0, 1'b1, 1'b1}, // R5 set
        '{8'h00, 8'h02, 1'b0, 1'b0, 3'd2, 1'b0, 1'b1, 1'b1}, // R5 hold
        '{8'h00, 8'h02, 1'b0, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0}, // R5 clear
        '{8'h04, 8'h0C, 1'b0, 1'b0, 3'd3, 1'b0, 1'b1, 1'b1}, // R6 set
        '{8'h04, 8'h0C, 1'b0, 1'b1, 3'd3, 1'b0, 1'b1, 1'b1}, // R6 S=R=1
        '{8'h00, 8'h0C, 1'b0, 1'b1, 3'd3, 1'b0, 1'b0, 1'b0}, // R6 clear
        '{8'h00, 8'h0C, 1'b0, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0}, // R6 hold
        '{8'h10, 8'h10, 1'b0, 1'b0, 3'd4, 1'b0, 1'b1, 1'b1}, // R7 capture
        '{8'h00, 8'h10, 1'b0, 1'b0, 3'd5, 1'b0, 1'b1, 1'b1}, // R11 hold
        '{8'h00, 8'h10, 1'b0, 1'b0, 3'd7, 1'b1, 1'b0, 1'b1}, // R8 R11
        '{8'h00, 8'hFF, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0}, // R8 D load 0
        '{8'h00, 8'h00, 1'b1, 1'b0, 3'd6, 1'b1, 1'b1, 1'b0}  // R9 fb differs
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #5;
        check("R10 reset fb", fb_out, 1'b0);
        check("R10 reset out", mc_out, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            pterm = VECS[i].pt; alloc_mask = VECS[i].mk; invert = VECS[i].inv;
            kr_term = VECS[i].kr; ff_mode = VECS[i].md; bypass = VECS[i].byp;
            @(posedge clk);
            #5;
            check($sformatf("vec%0d out (R1-R11 table)", i), mc_out, VECS[i].eo);
            check($sformatf("vec%0d fb R9", i), fb_out, VECS[i].ef);
        end
        // R7 transparent follows mid-cycle change
        @(negedge clk);
        ff_mode = 3'd4; bypass = 1'b0; invert = 1'b0; alloc_mask = 8'h20; pterm = 8'h20;
        #2;
        check("R7 transparent same cycle", mc_out, 1'b1);
        pterm = 8'h00;
        #2;
        check("R7 transparent drops", mc_out, 1'b0);
        // R10 async clear between edges
        @(negedge clk);
        ff_mode = 3'd0; pterm = 8'h20;
        @(posedge clk);
        #5;
        check("R3 load before reset", fb_out, 1'b1);
        rst_n = 1'b0;
        #2;
        check("R10 async clear", fb_out, 1'b0);
        #10;
        rst_n = 1'b1;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule